// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block takes over the control path of a small 16-bit processor core once an interrupt has been accepted. A hardware request is serviced only when the running instruction finishes. A long string-class instruction is instead halted at once and resumes later. A software interrupt instruction starts the entry straight away.

Once started, the sequencer runs a fixed entry of seven cycles. First it reads an information word from a fixed memory address. Next it writes the flag register back with the enable, debug and stack-select bits cleared. It then pushes three words onto a downward-growing stack: the flags as they were before the entry, the upper PC bits and the lower PC word. After that it loads the new priority level into the flag register. Last, it hands the interrupt number to the fetch unit with a one-cycle done pulse.

A response-time meter reports how many cycles passed from acceptance to done, counting both ends. The core supplies the flags, stack pointer and PC. It writes back whatever the sequencer drives while the matching write strobe is high.

Top module: `irq_entry_seq`

## Requirements
- R1: A hardware request is accepted only when flag bit 6 (interrupt enable) is 1 and `irq_lvl` is strictly greater than the priority field in flag bits 14:12. A software interrupt (`swi_req`) is always accepted and wins over a hardware request in the same cycle.
- R2: For a hardware request, the information read happens in the cycle after the first cycle, counting the acceptance cycle, in which `insn_last` is 1. If `insn_is_string` is 1 instead, the read happens in the cycle after acceptance, and `stop_insn` is 1 in the acceptance cycle.
- R3: The first memory access of an entry is a read at address 0. The word read back carries the interrupt number in bits 5:0 and the level in bits 10:8.
- R4: One cycle after the read, `flg_we` pulses. `flg_out` then equals the flags sampled just before the read cycle, with bits 6 (enable), 2 (debug) and 7 (stack select) cleared.
- R5: For a software interrupt numbered 32 to 63, bit 7 keeps its prior value in every flag write. For numbers 0 to 31 it is cleared.
- R6: In the next three cycles the sequencer makes three writes. Each write goes to an address one below the previous one, with wrap-around in 16 bits: first SP-1, then SP-2, then SP-3. The data written are, in order, the saved pre-entry flags, the PC bits 19:16 zero-extended, and PC bits 15:0. Each write has `sp_we` high and `sp_out` equal to the address just written.
- R7: In the cycle after the last push, `flg_we` pulses again. `flg_out` then equals the cleared flags with bits 14:12 replaced by the level from the information word.
- R8: `done` is high for one cycle right after the level write. In that cycle `vec_num` holds `swi_num` for a software interrupt, or the number from the information word otherwise. `busy` is high from the cycle after acceptance through the done cycle and low in the cycle after done. Out of reset, `busy`, `done`, `mem_req` and `resp_cycles` are 0.
- R9: After done, `resp_cycles` equals k + 7. Here k is the number of cycles from acceptance up to and including the cycle with `insn_last` high. When the start does not wait for `insn_last`, k is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Hardware interrupt request |
| irq_lvl | input | 3 | Level of the hardware request |
| swi_req | input | 1 | Software interrupt instruction is completing |
| swi_num | input | 6 | Software interrupt number |
| insn_last | input | 1 | Current instruction completes this cycle |
| insn_is_string | input | 1 | Current instruction is a suspendable string-class instruction |
| flg_in | input | 16 | Current flag register |
| sp_in | input | 16 | Current stack pointer |
| pc_in | input | 20 | Resume address |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | 20 | Memory address |
| mem_wdata | output | 16 | Write data |
| flg_we | output | 1 | Flag register write strobe |
| flg_out | output | 16 | New flag value |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_out | output | 16 | New stack pointer |
| busy | output | 1 | Entry in progress |
| done | output | 1 | Handler start pulse |
| vec_num | output | 6 | Interrupt number for the fetch unit |
| stop_insn | output | 1 | Halt the running string instruction |
| resp_cycles | output | 8 | Last measured response time |

## Verification
Every result is timed from the acceptance cycle, cycle 0, and the instruction-end cycle, k-1:
- the information read falls in cycle k;
- the cleared-flag write falls in cycle k+1;
- the three pushes fall in cycles k+2 to k+4;
- the level write falls in cycle k+5;
- done falls in cycle k+6.

`resp_cycles` is read one cycle after done. `stop_insn` is a combinational output of the acceptance cycle and is sampled in that cycle. The bench drives inputs on the falling edge and samples on the same falling edge after each rising edge, so each cycle's outputs are compared against the cycle number the bench expects. A strobe that shows up early, late or out of order therefore fails with its cycle index.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int FLG_W    = 16;
    localparam int NUM_W    = 6;
    localparam int IPL_W    = 3;
    localparam int FB_DBG   = 2;
    localparam int FB_IEN   = 6;
    localparam int FB_STK   = 7;
    localparam int IPL_LO   = 12;
    localparam int INFO_NUM_LO = 0;
    localparam int INFO_LVL_LO = 8;
    localparam int ENTRY_LEN   = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_SAVE,
        ST_PUSH_F,
        ST_PUSH_H,
        ST_PUSH_L,
        ST_LOAD_IPL,
        ST_DONE
    } ent_state_t;

    typedef struct packed {
        logic             is_sw;
        logic [NUM_W-1:0] num;
    } ent_src_t;

    typedef struct packed {
        logic [NUM_W-1:0] num;
        logic [IPL_W-1:0] lvl;
    } ent_info_t;

    function automatic logic [IPL_W-1:0] ipl_of(input logic [FLG_W-1:0] f);
        return f[IPL_LO +: IPL_W];
    endfunction

    function automatic logic [FLG_W-1:0] entry_clear(input logic [FLG_W-1:0] f,
                                                     input logic keep_stk);
        logic [FLG_W-1:0] r;
        r = f;
        r[FB_IEN] = 1'b0;
        r[FB_DBG] = 1'b0;
        if (!keep_stk) r[FB_STK] = 1'b0;
        return r;
    endfunction

    function automatic logic [FLG_W-1:0] with_ipl(input logic [FLG_W-1:0] f,
                                                  input logic [IPL_W-1:0] lvl);
        logic [FLG_W-1:0] r;
        r = f;
        r[IPL_LO +: IPL_W] = lvl;
        return r;
    endfunction

endpackage

// File: rtl/irq_accept.sv
module irq_accept
    import irq_entry_pkg::*;
(
    input  logic             irq_req,
    input  logic [IPL_W-1:0] irq_lvl,
    input  logic             swi_req,
    input  logic [FLG_W-1:0] flg_in,
    output logic             take,
    output logic             take_sw
);
    logic hw_ok;

    always_comb begin
        hw_ok   = irq_req && flg_in[FB_IEN] && (irq_lvl > ipl_of(flg_in));
        take_sw = swi_req;
        take    = swi_req || hw_ok;
    end

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
#(
    parameter int PC_W      = 20,
    parameter int SP_W      = 16,
    parameter int DATA_W    = 16,
    parameter int INFO_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              take_sw,
    input  logic [NUM_W-1:0]  swi_num,
    input  logic              insn_last,
    input  logic              insn_is_string,
    input  logic [FLG_W-1:0]  flg_in,
    input  logic [SP_W-1:0]   sp_in,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PC_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              flg_we,
    output logic [FLG_W-1:0]  flg_out,
    output logic              sp_we,
    output logic [SP_W-1:0]   sp_out,
    output logic              busy,
    output logic              done,
    output logic [NUM_W-1:0]  vec_num,
    output logic              stop_insn,
    output logic              accept
);
    localparam int HI_W  = PC_W - DATA_W;
    localparam int PAD_W = DATA_W - HI_W;

    ent_state_t        st_q, st_d;
    ent_src_t          src_q;
    ent_info_t         info_q;
    logic [FLG_W-1:0]  tmp_flg_q;
    logic [FLG_W-1:0]  work_flg_q;
    logic [PC_W-1:0]   pc_q;
    logic [SP_W-1:0]   sp_q;
    logic [SP_W-1:0]   sp_dec;
    logic              go_now;
    logic              launch;
    logic              keep_stk;
    logic [FLG_W-1:0]  cleared;

    always_comb begin
        go_now   = insn_last || insn_is_string;
        accept   = (st_q == ST_IDLE) && take;
        launch   = (accept && (take_sw || go_now)) || ((st_q == ST_WAIT) && go_now);
        stop_insn = launch && insn_is_string && !insn_last && !(accept && take_sw);
        keep_stk = src_q.is_sw && src_q.num[NUM_W-1];
        cleared  = entry_clear(tmp_flg_q, keep_stk);
        sp_dec   = sp_q - 1'b1;
        busy     = (st_q != ST_IDLE);
        done     = (st_q == ST_DONE);
        vec_num  = src_q.is_sw ? src_q.num : info_q.num;
    end

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:     if (take) st_d = (take_sw || go_now) ? ST_READ : ST_WAIT;
            ST_WAIT:     if (go_now) st_d = ST_READ;
            ST_READ:     st_d = ST_SAVE;
            ST_SAVE:     st_d = ST_PUSH_F;
            ST_PUSH_F:   st_d = ST_PUSH_H;
            ST_PUSH_H:   st_d = ST_PUSH_L;
            ST_PUSH_L:   st_d = ST_LOAD_IPL;
            ST_LOAD_IPL: st_d = ST_DONE;
            ST_DONE:     st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = PC_W'(INFO_ADDR);
        mem_wdata = '0;
        flg_we    = 1'b0;
        flg_out   = work_flg_q;
        sp_we     = 1'b0;
        sp_out    = sp_q;
        case (st_q)
            ST_READ: mem_req = 1'b1;
            ST_SAVE: begin
                flg_we  = 1'b1;
                flg_out = cleared;
            end
            ST_PUSH_F, ST_PUSH_H, ST_PUSH_L: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {{HI_W{1'b0}}, sp_dec};
                sp_we    = 1'b1;
                sp_out   = sp_dec;
                if (st_q == ST_PUSH_F)      mem_wdata = tmp_flg_q;
                else if (st_q == ST_PUSH_H) mem_wdata = {{PAD_W{1'b0}}, pc_q[PC_W-1:DATA_W]};
                else                        mem_wdata = pc_q[DATA_W-1:0];
            end
            ST_LOAD_IPL: begin
                flg_we  = 1'b1;
                flg_out = with_ipl(work_flg_q, info_q.lvl);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            src_q      <= '0;
            info_q     <= '0;
            tmp_flg_q  <= '0;
            work_flg_q <= '0;
            pc_q       <= '0;
            sp_q       <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                src_q.is_sw <= take_sw;
                src_q.num   <= swi_num;
            end
            if (launch) begin
                tmp_flg_q <= flg_in;
                pc_q      <= pc_in;
                sp_q      <= sp_in;
            end
            if (st_q == ST_SAVE) begin
                info_q.num <= mem_rdata[INFO_NUM_LO +: NUM_W];
                info_q.lvl <= mem_rdata[INFO_LVL_LO +: IPL_W];
                work_flg_q <= cleared;
            end
            if (sp_we) sp_q <= sp_dec;
        end
    end

    // R2: the information read only follows an instruction end, a string halt or a software trap
    p_start_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_READ) |-> $past(insn_last || insn_is_string || take_sw));

    // R3: every read of the entry targets the information address
    p_info_read_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (mem_addr == PC_W'(INFO_ADDR)));

    // R4: no flag write ever leaves enable or debug set
    p_flags_clear_r4: assert property (@(posedge clk) disable iff (rst)
        flg_we |-> (!flg_out[FB_IEN] && !flg_out[FB_DBG]));

    // R6: consecutive pushes walk downward by one word
    p_push_down_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |->
            (mem_addr[SP_W-1:0] == SP_W'($past(mem_addr[SP_W-1:0]) - 1'b1)));

    // R8: the entry ends the cycle after done
    p_done_ends_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: rtl/irq_resp_meter.sv
module irq_resp_meter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             busy,
    input  logic             done,
    output logic [CNT_W-1:0] resp_cycles
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            resp_cycles <= '0;
        end else begin
            if (accept)    cnt_q <= CNT_W'(1);
            else if (busy) cnt_q <= cnt_inc;
            if (done) resp_cycles <= cnt_inc;
        end
    end

    // R9: a result is only published at the end of an entry
    p_resp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(done) |-> $stable(resp_cycles));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int PC_W      = 20,
    parameter int SP_W      = 16,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 8,
    parameter int INFO_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req,
    input  logic [IPL_W-1:0]  irq_lvl,
    input  logic              swi_req,
    input  logic [NUM_W-1:0]  swi_num,
    input  logic              insn_last,
    input  logic              insn_is_string,
    input  logic [FLG_W-1:0]  flg_in,
    input  logic [SP_W-1:0]   sp_in,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PC_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              flg_we,
    output logic [FLG_W-1:0]  flg_out,
    output logic              sp_we,
    output logic [SP_W-1:0]   sp_out,
    output logic              busy,
    output logic              done,
    output logic [NUM_W-1:0]  vec_num,
    output logic              stop_insn,
    output logic [CNT_W-1:0]  resp_cycles
);
    logic take, take_sw, accept;

    irq_accept u_accept (
        .irq_req (irq_req),
        .irq_lvl (irq_lvl),
        .swi_req (swi_req),
        .flg_in  (flg_in),
        .take    (take),
        .take_sw (take_sw)
    );

    irq_entry_fsm #(
        .PC_W      (PC_W),
        .SP_W      (SP_W),
        .DATA_W    (DATA_W),
        .INFO_ADDR (INFO_ADDR)
    ) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .take           (take),
        .take_sw        (take_sw),
        .swi_num        (swi_num),
        .insn_last      (insn_last),
        .insn_is_string (insn_is_string),
        .flg_in         (flg_in),
        .sp_in          (sp_in),
        .pc_in          (pc_in),
        .mem_rdata      (mem_rdata),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .flg_we         (flg_we),
        .flg_out        (flg_out),
        .sp_we          (sp_we),
        .sp_out         (sp_out),
        .busy           (busy),
        .done           (done),
        .vec_num        (vec_num),
        .stop_insn      (stop_insn),
        .accept         (accept)
    );

    irq_resp_meter #(.CNT_W(CNT_W)) u_meter (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .busy        (busy),
        .done        (done),
        .resp_cycles (resp_cycles)
    );

    // R1: an entry only starts from a trap or a qualifying hardware request
    p_accept_rule_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(swi_req || (irq_req && flg_in[FB_IEN] &&
                                          (irq_lvl > flg_in[IPL_LO +: IPL_W]))));

endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        irq_req, swi_req, insn_last, insn_is_string;
    logic [2:0]  irq_lvl;
    logic [5:0]  swi_num;
    logic [15:0] flg_in, sp_in, info;
    logic [19:0] pc_in;
    logic        mem_req, mem_we, flg_we, sp_we, busy, done, stop_insn;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, flg_out, sp_out;
    logic [5:0]  vec_num;
    logic [7:0]  resp_cycles;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_entry_seq dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .swi_req(swi_req), .swi_num(swi_num), .insn_last(insn_last),
        .insn_is_string(insn_is_string), .flg_in(flg_in), .sp_in(sp_in),
        .pc_in(pc_in), .mem_rdata(info), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .flg_we(flg_we),
        .flg_out(flg_out), .sp_we(sp_we), .sp_out(sp_out), .busy(busy),
        .done(done), .vec_num(vec_num), .stop_insn(stop_insn),
        .resp_cycles(resp_cycles)
    );

    typedef struct packed {
        logic        sw;
        logic [5:0]  swn;
        logic        str;
        logic [3:0]  k;
        logic [15:0] flg;
        logic [2:0]  lvl;
        logic [15:0] sp;
        logic [19:0] pc;
        logic [15:0] info;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{sw:1'b0, swn:6'd0,  str:1'b0, k:4'd1, flg:16'h10C5, lvl:3'd3, sp:16'h0400, pc:20'h51234, info:16'h0315},
        '{sw:1'b0, swn:6'd0,  str:1'b0, k:4'd4, flg:16'h2041, lvl:3'd5, sp:16'h8000, pc:20'hF0002, info:16'h0512},
        '{sw:1'b0, swn:6'd0,  str:1'b1, k:4'd9, flg:16'h00C0, lvl:3'd7, sp:16'h0003, pc:20'h00100, info:16'h0701},
        '{sw:1'b1, swn:6'd40, str:1'b0, k:4'd1, flg:16'h7084, lvl:3'd0, sp:16'h1000, pc:20'h12345, info:16'h0400},
        '{sw:1'b1, swn:6'd5,  str:1'b0, k:4'd1, flg:16'h00C4, lvl:3'd0, sp:16'h2000, pc:20'h00F00, info:16'h0200},
        '{sw:1'b0, swn:6'd0,  str:1'b0, k:4'd2, flg:16'h0040, lvl:3'd1, sp:16'h0001, pc:20'hABCDE, info:16'h0133}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        irq_req = 1'b0; swi_req = 1'b0; insn_last = 1'b0; insn_is_string = 1'b0;
        irq_lvl = '0; swi_num = '0;
    endtask

    task automatic run_vec(input vec_t v);
        int          exp_done, done_at, rd_at, nw, nf;
        logic        keep_u;
        logic [15:0] exp_clr, exp_ipl, exp_sp;
        logic [15:0] exp_data [3];
        keep_u   = v.sw && v.swn[5];
        exp_clr  = v.flg & ~16'h00C4;
        if (keep_u) exp_clr = exp_clr | (v.flg & 16'h0080);
        exp_ipl  = (exp_clr & 16'h8FFF) | (16'(v.info[10:8]) << 12);
        exp_done = (v.sw || v.str) ? 7 : int'(v.k) + 6;
        exp_data[0] = v.flg;
        exp_data[1] = {12'h000, v.pc[19:16]};
        exp_data[2] = v.pc[15:0];
        done_at = -1; rd_at = -1; nw = 0; nf = 0;
        @(negedge clk);
        flg_in = v.flg; sp_in = v.sp; pc_in = v.pc; info = v.info;
        insn_is_string = v.str;
        insn_last = !v.sw && !v.str && (v.k == 4'd1);
        irq_req = !v.sw; irq_lvl = v.lvl; swi_req = v.sw; swi_num = v.swn;
        #1;
        chk("R2 stop_insn in acceptance cycle", 32'(stop_insn), 32'(v.str && !v.sw));
        for (int j = 1; j <= 40 && done_at < 0; j++) begin
            @(posedge clk);
            @(negedge clk);
            irq_req = 1'b0; swi_req = 1'b0;
            insn_last = !v.sw && !v.str && (j == int'(v.k) - 1);
            chk("R8 busy during entry", 32'(busy), 32'd1);
            if (mem_req && !mem_we) begin
                rd_at = j;
                chk("R3 read address", 32'(mem_addr), 32'd0);
            end
            if (mem_req && mem_we) begin
                exp_sp = v.sp - 16'(nw + 1);
                if (nw < 3) begin
                    chk("R6 push address", 32'(mem_addr), 32'({4'h0, exp_sp}));
                    chk("R6 push data", 32'(mem_wdata), 32'(exp_data[nw]));
                    chk("R6 stack pointer update", 32'({sp_we, sp_out}), 32'({1'b1, exp_sp}));
                    chk("R6 push cycle", 32'(j), 32'(exp_done - 4 + nw));
                end
                nw++;
            end
            if (flg_we) begin
                if (nf == 0) begin
                    chk("R4 R5 cleared flags", 32'(flg_out), 32'(exp_clr));
                    chk("R4 clear cycle", 32'(j), 32'(exp_done - 5));
                end else begin
                    chk("R7 R5 level flags", 32'(flg_out), 32'(exp_ipl));
                    chk("R7 level cycle", 32'(j), 32'(exp_done - 1));
                end
                nf++;
            end
            if (done) begin
                done_at = j;
                chk("R8 vector number", 32'(vec_num), v.sw ? 32'(v.swn) : 32'(v.info[5:0]));
            end
        end
        chk("R2 R8 done cycle", 32'(done_at), 32'(exp_done));
        chk("R2 R3 read cycle", 32'(rd_at), 32'(exp_done - 6));
        chk("R6 push count", 32'(nw), 32'd3);
        chk("R4 R7 flag write count", 32'(nf), 32'd2);
        @(posedge clk);
        @(negedge clk);
        chk("R8 busy low after done", 32'(busy), 32'd0);
        chk("R9 response cycles", 32'(resp_cycles), 32'(exp_done + 1));
        idle_inputs();
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        flg_in = '0; sp_in = '0; pc_in = '0; info = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        chk("R8 reset busy", 32'(busy), 32'd0);
        chk("R8 reset done", 32'(done), 32'd0);
        chk("R8 reset mem_req", 32'(mem_req), 32'd0);
        chk("R8 reset resp_cycles", 32'(resp_cycles), 32'd0);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R1: enable flag clear blocks a high-level request
        @(negedge clk);
        flg_in = 16'h0000; irq_req = 1'b1; irq_lvl = 3'd7; insn_last = 1'b1;
        repeat (4) begin
            @(posedge clk);
            @(negedge clk);
            chk("R1 rejected when enable is 0", 32'(busy), 32'd0);
        end
        // R1: equal level is not enough
        flg_in = 16'h3040; irq_lvl = 3'd3;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
            chk("R1 rejected at equal level", 32'(busy), 32'd0);
        end
        // R1: one level higher is accepted
        irq_lvl = 3'd4;
        @(posedge clk);
        @(negedge clk);
        irq_req = 1'b0;
        chk("R1 accepted above level", 32'(busy), 32'd1);
        for (int j = 0; j < 20 && busy; j++) begin
            @(posedge clk);
            @(negedge clk);
        end
        chk("R8 entry completes", 32'(busy), 32'd0);
        idle_inputs();

        // R1: software trap wins over a hardware request in the same cycle
        @(negedge clk);
        flg_in = 16'h0040; info = 16'h0107; irq_req = 1'b1; irq_lvl = 3'd6;
        swi_req = 1'b1; swi_num = 6'd33;
        for (int j = 1; j <= 7; j++) begin
            @(posedge clk);
            @(negedge clk);
            irq_req = 1'b0; swi_req = 1'b0;
        end
        chk("R1 software trap priority", 32'({done, vec_num}), 32'({1'b1, 6'd33}));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule